// File: doc/BRIEF.md
# Cascadable Vectored Priority Interrupt Controller

This block watches eight interrupt request lines and finds the most urgent one that is not masked. When it finds one, it raises one interrupt line to the processor. The processor then sends an acknowledge pulse. On that pulse the controller records the winning line as in service and returns an 8-bit vector for the processor's handler lookup. A handler of higher priority may start while a lower one is still running. A line of lower or equal priority waits until software writes an end-of-interrupt for the line that blocks it.

Two copies can be joined in a chain. The secondary's interrupt output feeds one request input of the primary, which gives fifteen usable sources. When the primary's winner is that link input, the primary leaves the bus alone and passes the acknowledge on. The secondary then supplies the vector. A source wired to secondary input 1 keeps working for software that still uses the old link line number.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, intrOut, vecOe and fwdAck are low, the in-service set is empty, the vector base is zero and no line is masked.
- R2: Line 0 has the highest priority and line 7 the lowest. One cycle after an eligible request is present, intrOut is high. A request is eligible when it is unmasked and no line of equal or higher priority is in service.
- R3: In the cycle after an acknowledge, intrOut is low. The winning line's in-service bit is then set.
- R4: In the cycle after an acknowledge, vecOe is high for exactly one cycle and vecOut = {base, line}, where the base is held in bits 7:3 and the 3-bit line number sits in bits 2:0. A write with cfgSel = 0 loads the base from cfgData[7:3].
- R5: A write with cfgSel = 1 loads the mask from cfgData. A line whose mask bit is 1 never raises intrOut. Clearing the bit lets its request through.
- R6: While a line is in service, a request on a higher-priority line raises intrOut. Requests on that line or on lower-priority lines leave intrOut low.
- R7: A write with cfgSel = 2 clears the in-service bit of line cfgData[2:0]. A request that was waiting then raises intrOut.
- R8: With CASCADE_EN = 1, an acknowledge whose winner is line CASCADE_LINE (default 2) produces a one-cycle fwdAck pulse and no vecOe. A secondary whose ackIn is driven by that fwdAck puts its own {base, line} vector out one cycle later.
- R9: An acknowledge while no request is eligible drives no vector, produces no fwdAck and changes no in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqReq | input | 8 | Level request lines, line 0 most urgent |
| ackIn | input | 1 | One-cycle acknowledge from the processor or from a primary's fwdAck |
| cfgWr | input | 1 | Programming write strobe |
| cfgSel | input | 2 | Write target: 0 base, 1 mask, 2 end-of-interrupt |
| cfgData | input | VEC_W | Programming data |
| intrOut | output | 1 | Interrupt request to the processor or to a primary's link input |
| vecOut | output | VEC_W | Vector of the acknowledged line |
| vecOe | output | 1 | Bus drive enable for vecOut |
| fwdAck | output | 1 | Acknowledge passed on to the secondary |

## Verification
The bench builds a chained pair. The primary uses CASCADE_EN = 1 with the link on line 2, and its fwdAck drives the secondary's ackIn. The secondary's intrOut drives primary request line 2. This setup reaches the forwarded-acknowledge path and the two-cycle vector delivery from the secondary, and it checks that the primary's link line stays in service while the secondary runs its handler. VEC_W is left at 8, so the base and line fields of the vector can be checked exactly.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_LINES = 8;
  localparam int unsigned PIC_IDX_W = $clog2(PIC_LINES);

  typedef enum logic [1:0] {
    CFG_BASE = 2'd0,
    CFG_MASK = 2'd1,
    CFG_EOI  = 2'd2
  } cfgSel_e;

  typedef struct packed {
    logic                 intrNext;
    logic                 takeAck;
    logic [PIC_IDX_W-1:0] ackIdx;
    logic                 drvVec;
    logic                 fwdAck;
    logic                 clrIsr;
    logic [PIC_IDX_W-1:0] eoiIdx;
    logic                 loadBase;
    logic                 loadMask;
  } picStrobes_t;
endpackage

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
#(
  parameter bit          CASCADE_EN   = 1'b0,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic [PIC_LINES-1:0] irqReq,
  input  logic [PIC_LINES-1:0] mask,
  input  logic [PIC_LINES-1:0] isr,
  input  logic                 ackIn,
  input  logic                 cfgWr,
  input  logic [1:0]           cfgSel,
  input  logic [PIC_IDX_W-1:0] eoiLine,
  output picStrobes_t          strb
);
  logic [PIC_LINES-1:0] pending;
  logic                 winValid;
  logic [PIC_IDX_W-1:0] winIdx;
  logic                 blocked;

  assign pending = irqReq & ~mask;

  // Scan from most to least urgent; an in-service line stops the scan,
  // so that line and everything below it must wait.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    blocked  = 1'b0;
    for (int i = 0; i < PIC_LINES; i++) begin
      if (!blocked && !winValid) begin
        if (isr[i]) begin
          blocked = 1'b1;
        end else if (pending[i]) begin
          winValid = 1'b1;
          winIdx   = PIC_IDX_W'(i);
        end
      end
    end
  end

  logic toLink;
  generate
    if (CASCADE_EN) begin : g_link
      assign toLink = (winIdx == PIC_IDX_W'(CASCADE_LINE));
    end else begin : g_noLink
      assign toLink = 1'b0;
    end
  endgenerate

  always_comb begin
    strb          = '0;
    strb.intrNext = winValid && !ackIn;
    strb.takeAck  = winValid && ackIn;
    strb.ackIdx   = winIdx;
    strb.fwdAck   = winValid && ackIn && toLink;
    strb.drvVec   = winValid && ackIn && !toLink;
    strb.clrIsr   = cfgWr && (cfgSel == CFG_EOI);
    strb.eoiIdx   = eoiLine;
    strb.loadBase = cfgWr && (cfgSel == CFG_BASE);
    strb.loadMask = cfgWr && (cfgSel == CFG_MASK);
  end
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  picStrobes_t          strb,
  input  logic [VEC_W-1:0]     cfgData,
  output logic [PIC_LINES-1:0] mask,
  output logic [PIC_LINES-1:0] isr,
  output logic                 intrOut,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecOe,
  output logic                 fwdAck
);
  localparam int unsigned BASE_W = VEC_W - PIC_IDX_W;

  logic [BASE_W-1:0] base;

  generate
    for (genvar g = 0; g < PIC_LINES; g++) begin : g_isr
      logic setBit, clrBit;
      assign setBit = strb.takeAck && (strb.ackIdx == PIC_IDX_W'(g));
      assign clrBit = strb.clrIsr && (strb.eoiIdx == PIC_IDX_W'(g));
      always_ff @(posedge clk) begin
        if (!rst_n)      isr[g] <= 1'b0;
        else if (setBit) isr[g] <= 1'b1;
        else if (clrBit) isr[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base    <= '0;
      mask    <= '0;
      intrOut <= 1'b0;
      vecOut  <= '0;
      vecOe   <= 1'b0;
      fwdAck  <= 1'b0;
    end else begin
      if (strb.loadBase) base <= cfgData[VEC_W-1:PIC_IDX_W];
      if (strb.loadMask) mask <= cfgData[PIC_LINES-1:0];
      intrOut <= strb.intrNext;
      vecOe   <= strb.drvVec;
      fwdAck  <= strb.fwdAck;
      if (strb.drvVec) vecOut <= {base, strb.ackIdx};
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned VEC_W        = 8,
  parameter bit          CASCADE_EN   = 1'b0,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIC_LINES-1:0] irqReq,
  input  logic                 ackIn,
  input  logic                 cfgWr,
  input  logic [1:0]           cfgSel,
  input  logic [VEC_W-1:0]     cfgData,
  output logic                 intrOut,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecOe,
  output logic                 fwdAck
);
  picStrobes_t          strb;
  logic [PIC_LINES-1:0] mask;
  logic [PIC_LINES-1:0] isr;

  pic_control #(.CASCADE_EN(CASCADE_EN), .CASCADE_LINE(CASCADE_LINE)) u_ctl (
    .irqReq (irqReq),
    .mask   (mask),
    .isr    (isr),
    .ackIn  (ackIn),
    .cfgWr  (cfgWr),
    .cfgSel (cfgSel),
    .eoiLine(cfgData[PIC_IDX_W-1:0]),
    .strb   (strb)
  );

  pic_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .cfgData(cfgData),
    .mask   (mask),
    .isr    (isr),
    .intrOut(intrOut),
    .vecOut (vecOut),
    .vecOe  (vecOe),
    .fwdAck (fwdAck)
  );
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] irqReq,
  input logic       ackIn,
  input logic       intrOut,
  input logic       vecOe,
  input logic       fwdAck
);
  a_r2_intr_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    intrOut |-> $past(|irqReq));
  a_r3_intr_low_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ackIn |=> !intrOut);
  a_r4_vec_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vecOe |-> $past(ackIn));
  a_r8_fwd_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    fwdAck |-> ($past(ackIn) && !vecOe));
  a_r9_idle_ack_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && !(|irqReq)) |=> (!vecOe && !fwdAck));
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (.*);

// File: tb/sim_pic_ctrl.sv
`timescale 1ns/1ps
module sim_pic_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] reqP = '0, reqS = '0;
  logic       ack = 1'b0, wrP = 1'b0, wrS = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] dat = '0;

  logic       intr0, oe0, fwd0, intr1, oe1, fwd1;
  logic [7:0] vec0, vec1;
  logic [7:0] reqP_in;
  assign reqP_in = {reqP[7:3], intr1, reqP[1:0]};

  pic_ctrl #(.CASCADE_EN(1'b1), .CASCADE_LINE(2)) u0 (
    .clk(clk), .rst_n(rst_n), .irqReq(reqP_in), .ackIn(ack), .cfgWr(wrP),
    .cfgSel(sel), .cfgData(dat), .intrOut(intr0), .vecOut(vec0), .vecOe(oe0),
    .fwdAck(fwd0));
  pic_ctrl u1 (
    .clk(clk), .rst_n(rst_n), .irqReq(reqS), .ackIn(fwd0), .cfgWr(wrS),
    .cfgSel(sel), .cfgData(dat), .intrOut(intr1), .vecOut(vec1), .vecOe(oe1),
    .fwdAck(fwd1));

  int nChecks = 0, nFail = 0;
  string curTag = "R1";

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model of both controllers
  int mBase[2], mMask[2], mIsr[2], mVec[2];
  bit mIntr[2], mOe[2], mFwd[2];

  function automatic int pickWin(int req, int msk, int ins);
    for (int i = 0; i < 8; i++) begin
      if (ins[i]) return -1;
      if (req[i] && !msk[i]) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        mBase[c] = 0; mMask[c] = 0; mIsr[c] = 0; mVec[c] = 0;
        mIntr[c] = 0; mOe[c] = 0; mFwd[c] = 0;
      end
    end else begin
      int req[2], ak[2], w[2];
      bit wr[2];
      req[0] = int'({reqP[7:3], mIntr[1], reqP[1:0]});
      req[1] = int'(reqS);
      ak[0] = int'(ack);
      ak[1] = int'(mFwd[0]);
      wr[0] = wrP; wr[1] = wrS;
      for (int c = 0; c < 2; c++) w[c] = pickWin(req[c], mMask[c], mIsr[c]);
      for (int c = 0; c < 2; c++) begin
        mOe[c] = 0; mFwd[c] = 0;
        mIntr[c] = (w[c] >= 0) && !ak[c];
        if (ak[c] != 0 && w[c] >= 0) begin
          mIsr[c] = mIsr[c] | (1 << w[c]);
          if (c == 0 && w[c] == 2) mFwd[c] = 1;
          else begin
            mOe[c] = 1;
            mVec[c] = (mBase[c] & 8'hF8) | w[c];
          end
        end
        if (wr[c]) begin
          if (sel == 2'd0) mBase[c] = int'(dat);
          if (sel == 2'd1) mMask[c] = int'(dat);
          if (sel == 2'd2) mIsr[c] = mIsr[c] & ~(1 << dat[2:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({curTag, " intr0"}, int'(intr0), int'(mIntr[0]));
      chk({curTag, " oe0"},   int'(oe0),   int'(mOe[0]));
      chk({curTag, " fwd0"},  int'(fwd0),  int'(mFwd[0]));
      chk({curTag, " intr1"}, int'(intr1), int'(mIntr[1]));
      chk({curTag, " oe1"},   int'(oe1),   int'(mOe[1]));
      if (oe0) chk({curTag, " vec0"}, int'(vec0), mVec[0]);
      if (oe1) chk({curTag, " vec1"}, int'(vec1), mVec[1]);
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(bit sec, logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    sel = s; dat = d;
    if (sec) wrS = 1'b1; else wrP = 1'b1;
    @(negedge clk);
    wrP = 1'b0; wrS = 1'b0;
  endtask

  task automatic doAck(output int v, output bit sawFwd);
    v = -1; sawFwd = 0;
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (fwd0) sawFwd = 1;
      if (oe0 && v < 0) v = int'(vec0);
      else if (oe1 && v < 0) v = int'(vec1);
      if (i == 0) chk("R3 intr low after ack", int'(intr0), 0);
      @(negedge clk);
    end
  endtask

  int v;
  bit f;

  initial begin
    waitCyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    curTag = "R1";
    chk("R1 intr0", int'(intr0), 0);
    chk("R1 oe0", int'(oe0), 0);
    chk("R1 fwd0", int'(fwd0), 0);

    cfg(0, 2'd0, 8'h20);
    cfg(1, 2'd0, 8'h70);

    curTag = "R2";
    reqP = 8'b0010_1000;
    waitCyc(2);
    chk("R2 intr0 raised", int'(intr0), 1);
    doAck(v, f);
    chk("R4 vector line3", v, 8'h23);
    curTag = "R6";
    waitCyc(2);
    chk("R6 lower waits", int'(intr0), 0);
    reqP[3] = 1'b0;
    curTag = "R7";
    cfg(0, 2'd2, 8'd3);
    waitCyc(2);
    chk("R7 waiting line served", int'(intr0), 1);
    doAck(v, f);
    chk("R4 vector line5", v, 8'h25);
    reqP[5] = 1'b0;
    cfg(0, 2'd2, 8'd5);

    curTag = "R6";
    reqP[6] = 1'b1;
    waitCyc(2);
    doAck(v, f);
    chk("R6 vector line6", v, 8'h26);
    reqP[7] = 1'b1;
    waitCyc(2);
    chk("R6 equal/lower blocked", int'(intr0), 0);
    reqP[4] = 1'b1;
    waitCyc(2);
    chk("R6 higher nests", int'(intr0), 1);
    doAck(v, f);
    chk("R6 nested vector", v, 8'h24);
    reqP[4] = 1'b0;
    cfg(0, 2'd2, 8'd4);
    reqP[6] = 1'b0;
    cfg(0, 2'd2, 8'd6);
    curTag = "R7";
    waitCyc(2);
    chk("R7 line7 after eoi", int'(intr0), 1);
    doAck(v, f);
    chk("R7 vector line7", v, 8'h27);
    reqP[7] = 1'b0;
    cfg(0, 2'd2, 8'd7);

    curTag = "R5";
    cfg(0, 2'd1, 8'h01);
    reqP[0] = 1'b1;
    waitCyc(3);
    chk("R5 masked silent", int'(intr0), 0);
    cfg(0, 2'd1, 8'h00);
    waitCyc(2);
    chk("R5 unmasked raises", int'(intr0), 1);
    doAck(v, f);
    chk("R5 vector line0", v, 8'h20);
    reqP[0] = 1'b0;
    cfg(0, 2'd2, 8'd0);

    curTag = "R8";
    reqS[1] = 1'b1;
    waitCyc(3);
    chk("R8 cascade raises primary", int'(intr0), 1);
    doAck(v, f);
    chk("R8 fwdAck seen", int'(f), 1);
    chk("R8 secondary vector line9", v, 8'h71);
    reqS[1] = 1'b0;
    cfg(1, 2'd2, 8'd1);
    cfg(0, 2'd2, 8'd2);
    waitCyc(2);
    chk("R8 link idle", int'(intr0), 0);

    curTag = "R9";
    doAck(v, f);
    chk("R9 no vector", v, -1);
    chk("R9 no fwd", int'(f), 0);
    reqP[1] = 1'b1;
    waitCyc(2);
    chk("R9 state intact", int'(intr0), 1);
    doAck(v, f);
    chk("R9 vector line1", v, 8'h21);
    reqP[1] = 1'b0;
    cfg(0, 2'd2, 8'd1);
    waitCyc(3);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule